// File: doc/BRIEF.md
# Four-Channel DMA Address and Register Core

This block is the programming interface and address generator of a four-channel DMA controller. A processor configures it through sixteen byte-wide ports. Through these ports it loads a 16-bit start address and a 16-bit transfer count for each channel. It also sets a per-channel transfer type and stepping direction, a command byte, and request and mask bits. It can read back the registers, a status byte and a fixed temporary value.

A device-side requester names a channel and a direction and gets an answer in the same cycle. If the direction does not fit the channel's programmed type, the access is refused. If it fits, the block returns the channel's current address and plain acceptance, or acceptance with end-of-process. At the next clock edge the address moves by one and the count drops by one.

Each 16-bit register is loaded or read as two bytes. The order of the bytes is set by one low/high toggle, which all eight per-channel ports share.

Top module: `dma4_core`

## Requirements
- R1: After reset, the toggle selects the low byte and all four mask bits are 1. Addresses, counts, transfer types, decrement bits, request flags, completion flags and the command byte are all 0.
- R2: Ports 0 to 7 reach the channel registers. Port bits [2:1] give the channel, and port bit 0 selects the count (1) or the address (0). The shared toggle gives the low byte first. It flips on every read or write of any of these eight ports.
- R3: A write to port 0xC returns the toggle to the low byte.
- R4: A write to port 0xD is a master reset. It returns the toggle to low, sets all mask bits, and clears every request and completion flag, even a completion raised in the same cycle. It keeps addresses, counts, modes and the command byte. Port 0xD reads as 0xFF, and the other ports from 0x9 to 0xF read as 0x00.
- R5: A write to port 0x8 stores the command byte, which appears on `ctrl_cfg` after the clock edge.
- R6: A write to port 0xB programs one channel. Bits [1:0] select the channel, bits [3:2] set the transfer type (0 verify, 1 write, 2 read, 3 invalid) and bit 5 sets decrement. Bits 4, 6 and 7 have no effect.
- R7: Port 0x9 sets or clears one request flag and port 0xA sets or clears one mask bit. In both, bits [1:0] select the channel and bit 2 gives the value. Port 0xF loads all mask bits from bits [3:0], and port 0xE clears all mask bits. The mask bits appear on `ch_mask`, with bit n for channel n.
- R8: Reading port 0x8 returns the completion flags in bits [3:0] and the request flags in bits [7:4], with bit n for channel n within each group. The read then clears all completion flags.
- R9: A device access is refused when a write access meets a channel whose type is not 1, or a read access meets a channel whose type is not 2. A refused access returns result 0 and address 0 and changes no state. With `dev_req` low the result is also 0.
- R10: An accepted access returns the channel's current address in the same cycle. At the next edge the address steps by one (down if decrement is set, up otherwise, wrapping at 16 bits) and the count drops by one.
- R11: An accepted access gives result 2 (end-of-process) when the count is 0 and the completion flag is clear, and result 1 otherwise. An accepted access at count 0 sets the completion flag. Stepping never clears it.
- R12: Bit n of `force_done` sets channel n's completion flag. A completion raised in the same cycle as a status read stays set.
- R13: If the processor writes a byte of a channel's address or count in the same cycle that an access steps that channel, the written register takes the byte and does not step. The other byte of that register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 4 | Processor port number |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_rd | input | 1 | Processor read strobe; side effects apply at the edge |
| cpu_wdata | input | DATA_W | Processor write byte |
| cpu_rdata | output | DATA_W | Read byte for the addressed port, combinational |
| dev_req | input | 1 | Device access request |
| dev_ch | input | 2 | Channel of the device access |
| dev_is_write | input | 1 | 1 for a write access, 0 for a read access |
| force_done | input | 4 | Per-channel completion set |
| dev_addr | output | 2*DATA_W | Address for an accepted access, else 0 |
| dev_result | output | 2 | 0 refused, 1 accepted, 2 accepted with end-of-process |
| ctrl_cfg | output | DATA_W | Stored command byte |
| ch_mask | output | 4 | Channel mask bits |

## Verification
The bench builds the block with its default DATA_W of 8. This gives 16-bit channel registers, so the count wrap from 0 to 0xFFFF and the address wrap are reached directly by loading small values. Random port traffic mixed with device accesses covers collisions between toggle flips, status clears, forced completions and stepping. Directed phases pin down the end-of-process sequence and its pre-set completion case.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {XF_VERIFY = 2'd0, XF_WRITE = 2'd1, XF_READ = 2'd2, XF_BAD = 2'd3} xfer_e;
  typedef enum logic [1:0] {RES_NONE = 2'd0, RES_OK = 2'd1, RES_EOP = 2'd2, RES_RSVD = 2'd3} res_e;

  localparam logic [3:0] P_CMD   = 4'h8;
  localparam logic [3:0] P_REQ   = 4'h9;
  localparam logic [3:0] P_MASK1 = 4'hA;
  localparam logic [3:0] P_MODE  = 4'hB;
  localparam logic [3:0] P_TGCLR = 4'hC;
  localparam logic [3:0] P_MRST  = 4'hD;
  localparam logic [3:0] P_MCLR  = 4'hE;
  localparam logic [3:0] P_MALL  = 4'hF;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreset,
  input  logic              wr_sel_addr,
  input  logic              wr_sel_cnt,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mode_wr,
  input  logic [1:0]        mode_xfer,
  input  logic              mode_dec,
  input  logic              mask_wr,
  input  logic              mask_val,
  input  logic              req_wr,
  input  logic              req_val,
  input  logic              step,
  input  logic              force_done,
  input  logic              stat_clr,
  output logic [REG_W-1:0]  addr_q,
  output logic [REG_W-1:0]  cnt_q,
  output logic [1:0]        xfer_q,
  output logic              mask_q,
  output logic              req_q,
  output logic              done_q,
  output logic              wrap
);
  logic [REG_W-1:0] addr_d, cnt_d;
  logic [1:0]       xfer_d;
  logic             dec_q, dec_d, mask_d, req_d, done_d, done_set;

  assign wrap = (cnt_q == '0);

  always_comb begin
    addr_d = addr_q;
    if (wr_sel_addr)
      addr_d = wr_hi ? {wdata, addr_q[DATA_W-1:0]} : {addr_q[REG_W-1:DATA_W], wdata};
    else if (step)
      addr_d = dec_q ? addr_q - REG_W'(1) : addr_q + REG_W'(1);

    cnt_d = cnt_q;
    if (wr_sel_cnt)
      cnt_d = wr_hi ? {wdata, cnt_q[DATA_W-1:0]} : {cnt_q[REG_W-1:DATA_W], wdata};
    else if (step)
      cnt_d = cnt_q - REG_W'(1);

    xfer_d = mode_wr ? mode_xfer : xfer_q;
    dec_d  = mode_wr ? mode_dec  : dec_q;
    mask_d = mreset ? 1'b1 : (mask_wr ? mask_val : mask_q);
    req_d  = mreset ? 1'b0 : (req_wr ? req_val : req_q);

    done_set = (step && wrap) || force_done;
    if (mreset)        done_d = 1'b0;
    else if (done_set) done_d = 1'b1;
    else if (stat_clr) done_d = 1'b0;
    else               done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      xfer_q <= '0;
      dec_q  <= 1'b0;
      mask_q <= 1'b1;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      xfer_q <= xfer_d;
      dec_q  <= dec_d;
      mask_q <= mask_d;
      req_q  <= req_d;
      done_q <= done_d;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_sel_cnt) |=> cnt_q == $past(cnt_q) - REG_W'(1)); // R10
  AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_sel_addr && !dec_q) |=> addr_q == $past(addr_q) + REG_W'(1)); // R10
  AST_WRAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap && !mreset) |=> done_q); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(step || force_done)); // R12
  AST_MRESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (mask_q && !req_q && !done_q)); // R4
endmodule

// File: rtl/dma4_access.sv
module dma4_access
  import dma4_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dev_req,
  input  logic [1:0]              dev_ch,
  input  logic                    dev_is_write,
  input  logic [2*NUM_CH-1:0]     xfer_flat,
  input  logic [REG_W*NUM_CH-1:0] addr_flat,
  input  logic [NUM_CH-1:0]       wrap_v,
  input  logic [NUM_CH-1:0]       done_v,
  output logic [NUM_CH-1:0]       step,
  output logic [REG_W-1:0]        dev_addr,
  output logic [1:0]              dev_result
);
  logic [1:0] sel_xfer;
  logic       ok;

  assign sel_xfer = xfer_flat[dev_ch*2 +: 2];
  assign ok = dev_req && (dev_is_write ? (sel_xfer == XF_WRITE) : (sel_xfer == XF_READ));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_step
    assign step[g] = ok && (dev_ch == 2'(g));
  end

  always_comb begin
    dev_addr   = '0;
    dev_result = RES_NONE;
    if (ok) begin
      dev_addr   = addr_flat[dev_ch*REG_W +: REG_W];
      dev_result = (wrap_v[dev_ch] && !done_v[dev_ch]) ? RES_EOP : RES_OK;
    end
  end

  AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_result == RES_NONE) |-> (step == '0 && dev_addr == '0)); // R9
endmodule

// File: rtl/dma4_core.sv
module dma4_core
  import dma4_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dev_req,
  input  logic [1:0]        dev_ch,
  input  logic              dev_is_write,
  input  logic [3:0]        force_done,
  output logic [REG_W-1:0]  dev_addr,
  output logic [1:0]        dev_result,
  output logic [DATA_W-1:0] ctrl_cfg,
  output logic [3:0]        ch_mask
);
  logic                    chan_port, is_cnt, mreset, stat_clr;
  logic [1:0]              pch;
  logic                    hi_q, hi_d;
  logic [DATA_W-1:0]       cmd_q, cmd_d;
  logic [REG_W*NUM_CH-1:0] addr_flat, cnt_flat;
  logic [2*NUM_CH-1:0]     xfer_flat;
  logic [NUM_CH-1:0]       wrap_v, done_v, req_v, mask_v, step_v;
  logic [REG_W-1:0]        sel_reg;

  assign chan_port = !cpu_addr[3];
  assign pch       = cpu_addr[2:1];
  assign is_cnt    = cpu_addr[0];
  assign mreset    = cpu_wr && (cpu_addr == P_MRST);
  assign stat_clr  = cpu_rd && (cpu_addr == P_CMD);

  always_comb begin
    hi_d = hi_q;
    if (mreset || (cpu_wr && cpu_addr == P_TGCLR)) hi_d = 1'b0;
    else if (chan_port && (cpu_wr || cpu_rd))      hi_d = ~hi_q;
    cmd_d = (cpu_wr && cpu_addr == P_CMD) ? cpu_wdata : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      cmd_q <= '0;
    end else begin
      hi_q  <= hi_d;
      cmd_q <= cmd_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic this_port, mode_wr, mask_wr, mask_val, req_wr;
    assign this_port = cpu_wr && chan_port && (pch == 2'(g));
    assign mode_wr   = cpu_wr && cpu_addr == P_MODE && cpu_wdata[1:0] == 2'(g);
    assign req_wr    = cpu_wr && cpu_addr == P_REQ && cpu_wdata[1:0] == 2'(g);
    assign mask_wr   = cpu_wr && ((cpu_addr == P_MASK1 && cpu_wdata[1:0] == 2'(g))
                                  || cpu_addr == P_MCLR || cpu_addr == P_MALL);
    assign mask_val  = (cpu_addr == P_MALL) ? cpu_wdata[g] :
                       (cpu_addr == P_MCLR) ? 1'b0 : cpu_wdata[2];

    dma4_chan #(.DATA_W(DATA_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .mreset     (mreset),
      .wr_sel_addr(this_port && !is_cnt),
      .wr_sel_cnt (this_port && is_cnt),
      .wr_hi      (hi_q),
      .wdata      (cpu_wdata),
      .mode_wr    (mode_wr),
      .mode_xfer  (cpu_wdata[3:2]),
      .mode_dec   (cpu_wdata[5]),
      .mask_wr    (mask_wr),
      .mask_val   (mask_val),
      .req_wr     (req_wr),
      .req_val    (cpu_wdata[2]),
      .step       (step_v[g]),
      .force_done (force_done[g]),
      .stat_clr   (stat_clr),
      .addr_q     (addr_flat[g*REG_W +: REG_W]),
      .cnt_q      (cnt_flat[g*REG_W +: REG_W]),
      .xfer_q     (xfer_flat[g*2 +: 2]),
      .mask_q     (mask_v[g]),
      .req_q      (req_v[g]),
      .done_q     (done_v[g]),
      .wrap       (wrap_v[g])
    );
  end

  dma4_access #(.DATA_W(DATA_W)) u_access (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_req     (dev_req),
    .dev_ch      (dev_ch),
    .dev_is_write(dev_is_write),
    .xfer_flat   (xfer_flat),
    .addr_flat   (addr_flat),
    .wrap_v      (wrap_v),
    .done_v      (done_v),
    .step        (step_v),
    .dev_addr    (dev_addr),
    .dev_result  (dev_result)
  );

  assign sel_reg = is_cnt ? cnt_flat[pch*REG_W +: REG_W] : addr_flat[pch*REG_W +: REG_W];

  always_comb begin
    if (chan_port)                 cpu_rdata = hi_q ? sel_reg[REG_W-1:DATA_W] : sel_reg[DATA_W-1:0];
    else if (cpu_addr == P_CMD)    cpu_rdata = DATA_W'({req_v, done_v});
    else if (cpu_addr == P_MRST)   cpu_rdata = '1;
    else                           cpu_rdata = '0;
  end

  assign ctrl_cfg = cmd_q;
  assign ch_mask  = mask_v;

  AST_TOGGLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (cpu_addr == P_TGCLR || cpu_addr == P_MRST)) |=> !hi_q); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_port && (cpu_wr || cpu_rd)) |=> hi_q != $past(hi_q)); // R2
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && force_done == '0 && step_v == '0) |=> done_v == '0); // R8
endmodule

// File: tb/tb_dma4_core.sv
module tb_dma4_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        dev_req = 1'b0, dev_is_write = 1'b0;
  logic [1:0]  dev_ch = '0;
  logic [3:0]  force_done = '0;
  logic [15:0] dev_addr;
  logic [1:0]  dev_result;
  logic [7:0]  ctrl_cfg;
  logic [3:0]  ch_mask;

  int vectors = 0;
  int fails = 0;

  // behavioural reference state
  logic [15:0] m_addr[4];
  logic [15:0] m_cnt[4];
  logic [1:0]  m_xfer[4];
  logic        m_dec[4];
  logic [3:0]  m_mask, m_req, m_done;
  logic        m_hi;
  logic [7:0]  m_cmd;

  always #10 clk = ~clk;

  dma4_core dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dev_req(dev_req), .dev_ch(dev_ch),
    .dev_is_write(dev_is_write), .force_done(force_done), .dev_addr(dev_addr),
    .dev_result(dev_result), .ctrl_cfg(ctrl_cfg), .ch_mask(ch_mask)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = '0; m_cnt[i] = '0; m_xfer[i] = '0; m_dec[i] = 1'b0;
    end
    m_mask = 4'hF; m_req = '0; m_done = '0; m_hi = 1'b0; m_cmd = '0;
  endtask

  function automatic logic accepted();
    return dev_req && ((dev_is_write && m_xfer[dev_ch] == 2'd1) ||
                       (!dev_is_write && m_xfer[dev_ch] == 2'd2));
  endfunction

  task automatic compare(input string tag);
    int exp_rd, exp_a, exp_r;
    logic [15:0] v;
    if (cpu_addr < 8) begin
      v = cpu_addr[0] ? m_cnt[cpu_addr[2:1]] : m_addr[cpu_addr[2:1]];
      exp_rd = m_hi ? int'(v[15:8]) : int'(v[7:0]);
    end else if (cpu_addr == 4'h8) exp_rd = int'({m_req, m_done});
    else if (cpu_addr == 4'hD)     exp_rd = 8'hFF;
    else                           exp_rd = 0;
    exp_a = 0; exp_r = 0;
    if (accepted()) begin
      exp_a = int'(m_addr[dev_ch]);
      exp_r = (m_cnt[dev_ch] == 16'h0 && !m_done[dev_ch]) ? 2 : 1;
    end
    check(tag, "cpu_rdata", int'(cpu_rdata), exp_rd);
    check(tag, "dev_addr", int'(dev_addr), exp_a);
    check(tag, "dev_result", int'(dev_result), exp_r);
    check(tag, "ctrl_cfg", int'(ctrl_cfg), int'(m_cmd));
    check(tag, "ch_mask", int'(ch_mask), int'(m_mask));
  endtask

  task automatic model_step();
    logic [3:0] fset;
    logic acc;
    int c;
    logic [15:0] r;
    fset = force_done;
    acc = accepted();
    c = dev_ch;
    if (acc) begin
      if (m_cnt[c] == 16'h0) fset[c] = 1'b1;
      if (!(cpu_wr && cpu_addr < 8 && cpu_addr[2:1] == 2'(c) && !cpu_addr[0]))
        m_addr[c] = m_dec[c] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
      if (!(cpu_wr && cpu_addr < 8 && cpu_addr[2:1] == 2'(c) && cpu_addr[0]))
        m_cnt[c] = m_cnt[c] - 16'd1;
    end
    if (cpu_wr && cpu_addr < 8) begin
      r = cpu_addr[0] ? m_cnt[cpu_addr[2:1]] : m_addr[cpu_addr[2:1]];
      if (m_hi) r[15:8] = cpu_wdata; else r[7:0] = cpu_wdata;
      if (cpu_addr[0]) m_cnt[cpu_addr[2:1]] = r; else m_addr[cpu_addr[2:1]] = r;
    end
    if (cpu_rd && cpu_addr == 4'h8) m_done = '0;
    m_done = m_done | fset;
    if ((cpu_wr || cpu_rd) && cpu_addr < 8) m_hi = ~m_hi;
    if (cpu_wr) begin
      case (cpu_addr)
        4'h8: m_cmd = cpu_wdata;
        4'h9: m_req[cpu_wdata[1:0]] = cpu_wdata[2];
        4'hA: m_mask[cpu_wdata[1:0]] = cpu_wdata[2];
        4'hB: begin m_xfer[cpu_wdata[1:0]] = cpu_wdata[3:2]; m_dec[cpu_wdata[1:0]] = cpu_wdata[5]; end
        4'hC: m_hi = 1'b0;
        4'hD: begin m_hi = 1'b0; m_mask = 4'hF; m_req = '0; m_done = '0; end
        4'hE: m_mask = '0;
        4'hF: m_mask = cpu_wdata[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic tick(input string tag, input logic [3:0] a, input logic w, input logic r,
                      input logic [7:0] d, input logic dq, input logic [1:0] dc,
                      input logic dw, input logic [3:0] fd);
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_rd = r; cpu_wdata = d;
    dev_req = dq; dev_ch = dc; dev_is_write = dw; force_done = fd;
    #2;
    compare(tag);
    @(posedge clk);
    model_step();
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
    tick(tag, a, 1'b1, 1'b0, d, 1'b0, 2'd0, 1'b0, 4'h0);
  endtask
  task automatic rd(input string tag, input logic [3:0] a);
    tick(tag, a, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 4'h0);
  endtask
  task automatic dev(input string tag, input logic [1:0] c, input logic w);
    tick(tag, 4'hC, 1'b0, 1'b0, 8'h00, 1'b1, c, w, 4'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen through status, readback and mask pins
    rd("R1", 4'h8);
    rd("R1", 4'h0);
    rd("R1", 4'h1);

    // R2: two-byte loads and readback through the shared toggle
    wr("R2", 4'h4, 8'h34); wr("R2", 4'h4, 8'h12);
    wr("R2", 4'h5, 8'h03); wr("R2", 4'h5, 8'h00);
    rd("R2", 4'h4); rd("R2", 4'h4); rd("R2", 4'h5); rd("R2", 4'h5);
    wr("R2", 4'h2, 8'hF0); wr("R2", 4'h3, 8'h01);

    // R3: toggle clear between a low and a repeated low byte
    wr("R3", 4'h0, 8'hAA); wr("R3", 4'hC, 8'h00); wr("R3", 4'h0, 8'hBB);
    rd("R3", 4'h0); rd("R3", 4'h0);

    // R6: ch2 write type; ch1 read type with decrement; ch0 ignored bits set
    wr("R6", 4'hB, 8'h06);
    wr("R6", 4'hB, 8'h29);
    wr("R6", 4'hB, 8'hD0);

    // R9: wrong direction, verify channel, no request
    dev("R9", 2'd2, 1'b0);
    dev("R9", 2'd0, 1'b1);
    tick("R9", 4'h8, 1'b0, 1'b0, 8'h00, 1'b0, 2'd2, 1'b1, 4'h0);

    // R10 / R11: count 3 -> three plain accepts, end-of-process, then plain
    dev("R10", 2'd2, 1'b1); dev("R10", 2'd2, 1'b1); dev("R10", 2'd2, 1'b1);
    dev("R11", 2'd2, 1'b1);
    dev("R11", 2'd2, 1'b1);

    // R8: status shows completion, then clears
    rd("R8", 4'h8); rd("R8", 4'h8);

    // R12: forced completion wins over a simultaneous status read
    tick("R12", 4'h8, 1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 4'h8);
    rd("R12", 4'h8);

    // R11: completion already set when count 0 is reached -> plain accept
    wr("R11", 4'hC, 8'h00);
    wr("R11", 4'h2, 8'h10); wr("R11", 4'h2, 8'h00);
    wr("R11", 4'h3, 8'h00); wr("R11", 4'h3, 8'h00);
    tick("R11", 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 4'h2);
    dev("R11", 2'd1, 1'b0); dev("R11", 2'd1, 1'b0);
    rd("R11", 4'h2); rd("R11", 4'h2);

    // R13: processor byte write collides with a step on the same register
    wr("R13", 4'hC, 8'h00);
    tick("R13", 4'h4, 1'b1, 1'b0, 8'h77, 1'b1, 2'd2, 1'b1, 4'h0);
    tick("R13", 4'h5, 1'b1, 1'b0, 8'h09, 1'b1, 2'd2, 1'b1, 4'h0);
    rd("R13", 4'h4); rd("R13", 4'h4);

    // R7: request and mask programming
    wr("R7", 4'h9, 8'h05); wr("R7", 4'h9, 8'h07); wr("R7", 4'h9, 8'h03);
    wr("R7", 4'hA, 8'h00); wr("R7", 4'hA, 8'h04);
    wr("R7", 4'hF, 8'h05); wr("R7", 4'hE, 8'h00);
    rd("R7", 4'h8);

    // R5: command byte
    wr("R5", 4'h8, 8'hA5); rd("R5", 4'h8);

    // R4: master reset, also against a same-cycle completion
    wr("R4", 4'h0, 8'h11);
    tick("R4", 4'hD, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 4'hF);
    rd("R4", 4'h8); rd("R4", 4'hD); rd("R4", 4'hE); rd("R4", 4'h0);

    // R10: mixed random traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      int op;
      a  = 4'($urandom_range(0, 15));
      op = $urandom_range(0, 9);
      d  = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
      if (a == 4'hD && $urandom_range(0, 7) != 0) a = 4'hB;
      tick("R10", a, op < 4, op >= 4 && op < 7, d, $urandom_range(0, 2) != 0,
           2'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule